// File: doc/BRIEF.md
# Two-Thread Shared Direction Predictor with Probabilistic Low-Priority Training

This block predicts branch directions for a core that runs two hardware threads: a high-priority (HP) thread and a background low-priority (LP) thread. Both threads share one table of 2-bit saturating counters. Each thread keeps its own global history register. The table index is the branch PC XORed with the history of the thread that asks, so branches from the two threads can collide on the same entry.

Training favours the HP thread. An HP resolve always moves the indexed counter one step toward the outcome. An LP resolve moves it only with probability 1/N, where N = 2^FRAC_LOG2. The choice is made by a Galois LFSR that steps only on LP resolves. Because of this, an LP branch that aliases onto an HP entry disturbs it only rarely.

After reset the block writes the weak not-taken value into every counter, one entry per cycle, and then raises `ready`. While `ready` is low, prediction requests and resolves are ignored.

Top module: `frac_bp_top`

## Requirements
- R1: After reset is released, `ready` rises exactly 2^IDX_W clock cycles later and then stays high until the next reset. At that point every counter holds 01 (weak not-taken), so every prediction is not-taken, and both history registers are zero.
- R2: A request accepted at a clock edge (`pred_req` high and `ready` high) produces `pred_valid` high after that edge. `pred_valid` is low after any edge with no accepted request. `pred_taken` is bit 1 of the counter at index `pred_pc` XOR history(`pred_hp`), read before any resolve at the same edge.
- R3: Counters encode 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. An applied update adds 1 on taken and subtracts 1 on not-taken, saturating at 11 and at 00.
- R4: A resolve with `res_hp`=1 (HP thread) always applies its update to the counter at `res_pc` XOR HP history. The table is shared, so the LP thread sees the change.
- R5: The LFSR is a W=LFSR_W-bit right-shifting Galois register: next = (s >> 1) XOR (s[0] ? LFSR_TAPS : 0). It starts at LFSR_SEED and steps only on accepted LP resolves. An LP resolve applies its update only when the low FRAC_LOG2 bits of the current LFSR state are all zero; otherwise the entry is left unchanged. With FRAC_LOG2=0 every LP resolve applies.
- R6: On every accepted resolve, the resolving thread's history shifts left by one and takes the outcome into bit 0, whether or not the counter changed. The other thread's history is untouched. `res_hp`/`pred_hp` = 1 selects the HP history and 0 selects the LP history.
- R7: A resolve presented while `ready` is low changes no counter, no history and no LFSR state. A prediction request presented while `ready` is low produces no `pred_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req | input | 1 | Prediction request |
| pred_hp | input | 1 | Requesting thread: 1 HP, 0 LP |
| pred_pc | input | IDX_W | PC bits used to index the table |
| res_valid | input | 1 | Resolve event |
| res_hp | input | 1 | Resolving thread: 1 HP, 0 LP |
| res_pc | input | IDX_W | PC bits of the resolved branch |
| res_taken | input | 1 | Actual branch outcome |
| ready | output | 1 | Table initialisation finished |
| pred_valid | output | 1 | Registered: a prediction is on `pred_taken` |
| pred_taken | output | 1 | Registered predicted direction |

## Verification
The bench drives several hazards on purpose:
- **Saturation at both ends.** A wrap-around would turn strong taken into strong not-taken and flip a later prediction.
- **Cross-thread aliasing.** Histories are chosen so that different PCs reach one entry. A wrong history select or shift shows up as a prediction read from the wrong entry.
- **LP gating against a reference LFSR.** An HP resolve is placed between two LP resolves. A design that steps the LFSR on HP resolves, or that gates the wrong bits, applies a skipped LP update or skips an applied one.
- **Prediction and resolve at the same edge, and stimulus during initialisation.** These catch read-after-write ordering and the missing ignore rule while `ready` is low.

// File: rtl/frac_bp_pkg.sv
package frac_bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    ctr_t r;
    r = c;
    if (up && c != 2'b11) r = c + 2'd1;
    else if (!up && c != 2'b00) r = c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/bp_lfsr_gate.sv
module bp_lfsr_gate #(
  parameter int              FRAC_LOG2 = 2,
  parameter int              LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] TAPS    = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED    = 8'h01
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_step,
  output logic lp_apply
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_nx;

  assign lfsr_nx = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (rst)          lfsr_q <= SEED;
    else if (lp_step) lfsr_q <= lfsr_nx;
  end

  generate
    if (FRAC_LOG2 == 0) begin : g_always
      assign lp_apply = 1'b1;
    end else begin : g_frac
      assign lp_apply = (lfsr_q[FRAC_LOG2-1:0] == '0);
    end
  endgenerate

  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
  p_lfsr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !lp_step |=> $stable(lfsr_q));
  p_lfsr_moves_r5: assert property (@(posedge clk) disable iff (rst)
    lp_step |=> !$stable(lfsr_q));

endmodule

// File: rtl/bp_history.sv
module bp_history #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sh_en,
  input  logic             sh_hp,
  input  logic             sh_taken,
  input  logic             rd_pred_hp,
  input  logic             rd_res_hp,
  output logic [IDX_W-1:0] hist_pred,
  output logic [IDX_W-1:0] hist_res
);

  localparam int NTHR = 2;

  logic [IDX_W-1:0] hist_q [NTHR];

  always_ff @(posedge clk) begin
    for (int t = 0; t < NTHR; t++) begin
      if (rst)
        hist_q[t] <= '0;
      else if (sh_en && (int'(sh_hp) == t))
        hist_q[t] <= {hist_q[t][IDX_W-2:0], sh_taken};
    end
  end

  assign hist_pred = hist_q[rd_pred_hp];
  assign hist_res  = hist_q[rd_res_hp];

  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_chk
      p_hist_shift_r6: assert property (@(posedge clk) disable iff (rst)
        sh_en && (int'(sh_hp) == t) |=> hist_q[t][0] == $past(sh_taken));
      p_hist_other_r6: assert property (@(posedge clk) disable iff (rst)
        !(sh_en && (int'(sh_hp) == t)) |=> $stable(hist_q[t]));
    end
  endgenerate

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import frac_bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic             ready,
  output logic             rd_valid,
  output logic             rd_taken
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  ctr_t             mem [ENTRIES];
  logic [IDX_W-1:0] sweep_ptr;
  ctr_t             cur;

  assign cur = mem[wr_idx];

  // Single write port: initial sweep, then read-modify-write on resolves.
  always_ff @(posedge clk) begin
    if (!ready)
      mem[sweep_ptr] <= CTR_RESET;
    else if (wr_en)
      mem[wr_idx] <= ctr_step(cur, wr_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_ptr <= '0;
      ready     <= 1'b0;
    end else if (!ready) begin
      sweep_ptr <= sweep_ptr + 1'b1;
      if (sweep_ptr == LAST) ready <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_taken <= 1'b0;
    end else begin
      rd_valid <= rd_en && ready;
      if (rd_en && ready) rd_taken <= mem[rd_idx][1];
    end
  end

  p_ready_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  p_rd_valid_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && ready));
  p_no_write_early_r7: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !wr_en);

endmodule

// File: rtl/frac_bp_top.sv
module frac_bp_top #(
  parameter int                IDX_W     = 6,
  parameter int                FRAC_LOG2 = 2,
  parameter int                LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pred_req,
  input  logic             pred_hp,
  input  logic [IDX_W-1:0] pred_pc,
  input  logic             res_valid,
  input  logic             res_hp,
  input  logic [IDX_W-1:0] res_pc,
  input  logic             res_taken,
  output logic             ready,
  output logic             pred_valid,
  output logic             pred_taken
);

  logic             res_fire;
  logic             lp_apply;
  logic             upd_en;
  logic [IDX_W-1:0] hist_pred;
  logic [IDX_W-1:0] hist_res;

  assign res_fire = res_valid && ready;
  assign upd_en   = res_fire && (res_hp || lp_apply);

  bp_lfsr_gate #(
    .FRAC_LOG2 (FRAC_LOG2),
    .LFSR_W    (LFSR_W),
    .TAPS      (LFSR_TAPS),
    .SEED      (LFSR_SEED)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .lp_step  (res_fire && !res_hp),
    .lp_apply (lp_apply)
  );

  bp_history #(.IDX_W(IDX_W)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .sh_en      (res_fire),
    .sh_hp      (res_hp),
    .sh_taken   (res_taken),
    .rd_pred_hp (pred_hp),
    .rd_res_hp  (res_hp),
    .hist_pred  (hist_pred),
    .hist_res   (hist_res)
  );

  bp_counter_table #(.IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (pred_req),
    .rd_idx   (pred_pc ^ hist_pred),
    .wr_en    (upd_en),
    .wr_idx   (res_pc ^ hist_res),
    .wr_taken (res_taken),
    .ready    (ready),
    .rd_valid (pred_valid),
    .rd_taken (pred_taken)
  );

  p_idle_no_pred_r2: assert property (@(posedge clk) disable iff (rst)
    !pred_req |=> !pred_valid);
  p_init_no_pred_r7: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !pred_valid);

endmodule

// File: tb/frac_bp_top_test.sv
module frac_bp_top_test;

  localparam int IDX_W   = 6;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int FRACN   = 4;
  localparam int TAPS    = 'hB8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pred_req = 1'b0, pred_hp = 1'b0;
  logic [IDX_W-1:0] pred_pc = '0;
  logic             res_valid = 1'b0, res_hp = 1'b0, res_taken = 1'b0;
  logic [IDX_W-1:0] res_pc = '0;
  logic             ready, pred_valid, pred_taken;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  frac_bp_top #(.IDX_W(IDX_W), .FRAC_LOG2(2)) uut (
    .clk(clk), .rst(rst),
    .pred_req(pred_req), .pred_hp(pred_hp), .pred_pc(pred_pc),
    .res_valid(res_valid), .res_hp(res_hp), .res_pc(res_pc), .res_taken(res_taken),
    .ready(ready), .pred_valid(pred_valid), .pred_taken(pred_taken)
  );

  // Behavioural reference model, advanced on every rising edge.
  int m_cnt [ENTRIES];
  int m_hist [2];
  int m_lfsr;
  int m_cycles;
  bit m_rdy;
  bit exp_pv, exp_pt;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) m_cnt[i] = 1;
      m_hist[0] = 0; m_hist[1] = 0;
      m_lfsr = 1; m_cycles = 0; m_rdy = 0;
      exp_pv = 0; exp_pt = 0;
    end else begin
      exp_pv = pred_req && m_rdy;
      if (exp_pv) exp_pt = ((m_cnt[pred_pc ^ m_hist[pred_hp]] >> 1) & 1) != 0;
      if (res_valid && m_rdy) begin
        int idx;
        bit apply;
        idx = res_pc ^ m_hist[res_hp];
        apply = 1;
        if (!res_hp) begin
          apply = (m_lfsr % FRACN) == 0;
          m_lfsr = (m_lfsr >> 1) ^ (((m_lfsr & 1) != 0) ? TAPS : 0);
        end
        if (apply) begin
          if (res_taken && m_cnt[idx] < 3) m_cnt[idx]++;
          else if (!res_taken && m_cnt[idx] > 0) m_cnt[idx]--;
        end
        m_hist[res_hp] = ((m_hist[res_hp] << 1) | int'(res_taken)) % ENTRIES;
      end
      m_cycles++;
      if (m_cycles == ENTRIES) m_rdy = 1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 ready", int'(ready), int'(m_rdy));
      check("R2 pred_valid", int'(pred_valid), int'(exp_pv));
      if (exp_pv) check("R2 pred_taken", int'(pred_taken), int'(exp_pt));
    end
  end

  task automatic predict(bit hp, int pc, string req, int exp);
    pred_req = 1; pred_hp = hp; pred_pc = IDX_W'(pc);
    @(negedge clk);
    pred_req = 0;
    check(req, int'(pred_valid), 1);
    check(req, int'(pred_taken), exp);
  endtask

  task automatic resolve(bit hp, int pc, bit tk);
    res_valid = 1; res_hp = hp; res_pc = IDX_W'(pc); res_taken = tk;
    @(negedge clk);
    res_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R7: traffic during initialisation must be ignored.
    for (int i = 0; i < ENTRIES - 2; i++) begin
      res_valid = 1; res_hp = i[0]; res_pc = 6'd5; res_taken = 1;
      pred_req = 1; pred_hp = 0; pred_pc = 6'd5;
      @(negedge clk);
      check("R7 no pred during init", int'(pred_valid), 0);
    end
    res_valid = 0; pred_req = 0;
    while (!ready) @(negedge clk);
    @(negedge clk);
    check("R2 idle pred_valid low", int'(pred_valid), 0);

    predict(0, 5, "R1 reset weak not-taken", 0);
    resolve(1, 5, 1);                           // idx5 01->10, hp hist 01
    predict(0, 5, "R4 HP update seen by LP", 1);
    predict(1, 4, "R6 HP history in index", 1); // 4^1 = 5
    resolve(1, 4, 1);                           // idx5 ->11, hist 03
    resolve(1, 6, 1);                           // idx5 saturates 11, hist 07
    resolve(1, 2, 0);                           // idx5 ->10, hist 0E
    resolve(1, 'h0B, 0);                        // idx5 ->01, hist 1C
    predict(0, 5, "R3 saturation at 11", 0);
    resolve(0, 9, 1);                           // R7/R5: lfsr=01, rnd 01 -> skipped
    predict(1, 'h15, "R5 LP update skipped", 0); // 15^1C = 9
    resolve(0, 8, 1);                           // lfsr=B8 -> applied, idx9 ->10
    predict(1, 'h15, "R5 LP update applied", 1);
    resolve(1, 'h3F, 0);                        // HP: lfsr must stay 5C, hist 38
    resolve(0, 'h0A, 0);                        // rnd 00 -> applied, idx9 ->01
    predict(1, 'h31, "R5 LFSR holds on HP resolve", 0); // 31^38 = 9

    // Mixed random traffic, checked by the model every cycle.
    for (int i = 0; i < 4000; i++) begin
      pred_req  = ($urandom % 4) != 0;
      pred_hp   = $urandom % 2;
      pred_pc   = IDX_W'($urandom);
      res_valid = ($urandom % 3) != 0;
      res_hp    = $urandom % 2;
      res_pc    = IDX_W'($urandom % 8);
      res_taken = ($urandom % 4) != 0;
      @(negedge clk);
    end
    pred_req = 0; res_valid = 0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule